// File: doc/BRIEF.md
# Removable-Card Slot Presence and Host-Enable Control

This block watches a removable-card slot and holds the slot's operating configuration. Two active-low detect pins come in from the connector. They pass through a synchronizer, and the block then judges one combined condition: the card is seated only when both pins read low. That combined condition is debounced by a cycle counter. Each time the debounced state changes, in either direction, the block emits a single-cycle event.

A small register port gives access to two registers. The first is a read-only status word that shows the synchronized pin levels. The second is a mode word holding:
- the interface mode,
- the card type,
- the card-reset control, which drives the reset pin,
- the output-tristate control,
- the two DMA enables,
- the data-request block size,
- a host-enable bit.

While host-enable is clear, the block holds the transfer datapath in reset through a dedicated output. The configuration bits keep their values during that time. Software can therefore soft-reset the controller by clearing host-enable and then setting it again.

Top module: `slot_ctl`

## Requirements
- R1: After reset, `cardPresent` and `cardEvent` are 0, the mode word reads 0, and `xferHold` is 1.
- R2: The card counts as present only when both `cdet1N` and `cdet2N` are low. A single low pin means absent and raises no event.
- R3: A change of the combined condition becomes visible on `cardPresent` exactly DEB_CYCLES+2 clock edges after the pins change. This count includes the two synchronizer stages. A condition that lasts fewer than DEB_CYCLES cycles has no effect.
- R4: `cardEvent` is high for exactly one cycle on every debounced change of `cardPresent`, both on insertion and on removal.
- R5: The status word sits at address 0x000. Bit 2 is the synchronized level of `cdet1N`, bit 3 the level of `cdet2N`, bit 5 `cardRdy` and bit 6 `ioRdy`. All other bits read 0, and writes to this address change nothing.
- R6: The mode word sits at address 0x00C. Its writable fields are:
  - bits 1:0: mode (0 memory, 1 I/O, 2 true IDE)
  - bit 2: enhanced card type
  - bit 3: card reset
  - bit 4: host enable
  - bit 5: output tristate
  - bit 8: ultra DMA enable
  - bit 9: multi-word DMA enable
  - bits 12:11: block size (0..3 for 512, 1024, 2048, 4096 bytes)

  All other bits read 0.
- R7: A write whose bits 1:0 equal 3 leaves the mode field unchanged, but updates every other writable field.
- R8: `cardResetOut`, `outTristate`, `ifMode`, `plusCard`, `udmaEn`, `mwdmaEn` and `blkSize` follow their mode-word fields from the cycle after the write.
- R9: `xferHold` is 1 exactly while bit 4 of the mode word is 0. Clearing bit 4 leaves the other mode fields unchanged.
- R10: Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cdet1N | input | 1 | First card-detect pin, low when seated |
| cdet2N | input | 1 | Second card-detect pin, low when seated |
| cardRdy | input | 1 | Card ready pin |
| ioRdy | input | 1 | I/O ready pin |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| cardPresent | output | 1 | Debounced presence |
| cardEvent | output | 1 | One-cycle pulse on presence change |
| cardResetOut | output | 1 | Card reset pin drive |
| outTristate | output | 1 | Tristate request for card outputs |
| xferHold | output | 1 | Holds transfer logic in reset |
| ifMode | output | 2 | Interface mode |
| plusCard | output | 1 | Enhanced card type |
| udmaEn | output | 1 | Ultra DMA enable |
| mwdmaEn | output | 1 | Multi-word DMA enable |
| blkSize | output | 2 | Data-request block size code |

## Verification
The presence logic is driven with several pin patterns:
- both pins low, which separates a correct AND of the two pins from an OR;
- only one pin low, which catches a detector that looks at a single pin;
- a both-low pulse shorter than the debounce window, which catches a missing or too-short filter;
- release after insertion, which proves that removal also raises an event.

The insertion edge is sampled on the exact cycle before and on the cycle of the flip, so that any off-by-one in the window is caught. The mode word is written with stray bits set, with the reserved mode value, and with host-enable alone toggled. These writes separate the write mask, the reserved-value rule and the retention of configuration during a soft reset.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int OFF_STATUS = 'h000;
  localparam int OFF_MODE   = 'h00C;
  localparam logic [31:0] MODE_MASK = 32'h0000_1B3F;

  typedef struct packed {
    logic det1Lvl;
    logic det2Lvl;
    logic rdyLvl;
    logic ioRdyLvl;
    logic present;
    logic evt;
  } slotSense_t;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rstVal,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[s] <= rstVal;
        else       stg[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[s] <= rstVal;
        else       stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/slot_detect.sv
module slot_detect
  import slot_pkg::*;
#(
  parameter int DEB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cdet1N,
  input  logic       cdet2N,
  input  logic       cardRdy,
  input  logic       ioRdy,
  output slotSense_t sense
);
  localparam int CNT_W = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;

  logic [3:0] pinSync;
  logic rawPresent;
  logic present;
  logic evt;
  logic [CNT_W-1:0] debCnt;

  slot_sync #(.W(4), .STAGES(2)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .din   ({ioRdy, cardRdy, cdet2N, cdet1N}),
    .rstVal(4'b0011),
    .dout  (pinSync)
  );

  // combined condition: seated only when both detect pins are low
  assign rawPresent = ~pinSync[0] & ~pinSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      present <= 1'b0;
      evt     <= 1'b0;
      debCnt  <= '0;
    end else begin
      evt <= 1'b0;
      if (rawPresent == present) begin
        debCnt <= '0;
      end else if (debCnt == CNT_W'(DEB_CYCLES - 1)) begin
        present <= rawPresent;
        evt     <= 1'b1;
        debCnt  <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  assign sense = '{det1Lvl: pinSync[0], det2Lvl: pinSync[1], rdyLvl: pinSync[2],
                   ioRdyLvl: pinSync[3], present: present, evt: evt};

  AST_EVT_ON_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    evt |-> (present != $past(present))); // R4
  AST_FLIP_HAS_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (present != $past(present)) |-> evt); // R4
  AST_PRESENT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(present) |-> $past(!pinSync[0] && !pinSync[1])); // R2
  AST_DEB_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (present != $past(present)) |-> ($past(debCnt) == CNT_W'(DEB_CYCLES - 1))); // R3
endmodule

// File: rtl/slot_regs.sv
module slot_regs
  import slot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotSense_t        sense,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [31:0]       modeWord
);
  logic selStatus, selMode;
  logic [31:0] modeNext;
  logic [31:0] statusWord;

  assign selStatus = (regAddr == ADDR_W'(OFF_STATUS));
  assign selMode   = (regAddr == ADDR_W'(OFF_MODE));

  always_comb begin
    modeNext = regWrData & MODE_MASK;
    if (regWrData[1:0] == 2'd3) modeNext[1:0] = modeWord[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  modeWord <= '0;
    else if (regWrEn && selMode) modeWord <= modeNext;
  end

  always_comb begin
    statusWord    = '0;
    statusWord[2] = sense.det1Lvl;
    statusWord[3] = sense.det2Lvl;
    statusWord[5] = sense.rdyLvl;
    statusWord[6] = sense.ioRdyLvl;
  end

  always_comb begin
    if (selStatus)    regRdData = statusWord;
    else if (selMode) regRdData = modeWord;
    else              regRdData = '0;
  end

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && selStatus) |=> $stable(modeWord)); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeWord[1:0] != 2'd3); // R7
  AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (modeWord & ~MODE_MASK) == 32'd0); // R6
endmodule

// File: rtl/slot_ctl.sv
module slot_ctl
  import slot_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cdet1N,
  input  logic              cdet2N,
  input  logic              cardRdy,
  input  logic              ioRdy,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              cardPresent,
  output logic              cardEvent,
  output logic              cardResetOut,
  output logic              outTristate,
  output logic              xferHold,
  output logic [1:0]        ifMode,
  output logic              plusCard,
  output logic              udmaEn,
  output logic              mwdmaEn,
  output logic [1:0]        blkSize
);
  slotSense_t sense;
  logic [31:0] modeWord;

  slot_detect #(.DEB_CYCLES(DEB_CYCLES)) u_detect (
    .clk(clk), .rstN(rstN), .cdet1N(cdet1N), .cdet2N(cdet2N),
    .cardRdy(cardRdy), .ioRdy(ioRdy), .sense(sense)
  );

  slot_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .sense(sense), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .modeWord(modeWord)
  );

  assign cardPresent  = sense.present;
  assign cardEvent    = sense.evt;
  assign ifMode       = modeWord[1:0];
  assign plusCard     = modeWord[2];
  assign cardResetOut = modeWord[3];
  assign xferHold     = ~modeWord[4];
  assign outTristate  = modeWord[5];
  assign udmaEn       = modeWord[8];
  assign mwdmaEn      = modeWord[9];
  assign blkSize      = modeWord[12:11];
endmodule

// File: tb/slot_ctl_tb_top.sv
module slot_ctl_tb_top;
  localparam int TB_DEB = 16;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cdet1N = 1'b1, cdet2N = 1'b1, cardRdy = 1'b0, ioRdy = 1'b0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic cardPresent, cardEvent, cardResetOut, outTristate, xferHold;
  logic plusCard, udmaEn, mwdmaEn;
  logic [1:0] ifMode, blkSize;

  int nChecks = 0;
  int nFails = 0;
  int evtCnt = 0;

  always #2 clk = ~clk;

  slot_ctl #(.DEB_CYCLES(TB_DEB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .cdet1N(cdet1N), .cdet2N(cdet2N),
    .cardRdy(cardRdy), .ioRdy(ioRdy), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cardPresent(cardPresent),
    .cardEvent(cardEvent), .cardResetOut(cardResetOut), .outTristate(outTristate),
    .xferHold(xferHold), .ifMode(ifMode), .plusCard(plusCard), .udmaEn(udmaEn),
    .mwdmaEn(mwdmaEn), .blkSize(blkSize)
  );

  always @(negedge clk) if (rstN && cardEvent) evtCnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rdReg(12'h00C, d);
    check("R1 mode word", d, 32'h0);
    check("R1 present", {31'd0, cardPresent}, 32'd0);
    check("R1 event", {31'd0, cardEvent}, 32'd0);
    check("R1 xferHold", {31'd0, xferHold}, 32'd1);
  endtask

  task automatic t_insert();
    int e0 = evtCnt;
    @(negedge clk);
    cdet1N = 1'b0; cdet2N = 1'b0;
    repeat (TB_DEB + 1) @(negedge clk);
    check("R3 not early", {31'd0, cardPresent}, 32'd0);
    @(negedge clk);
    check("R3 flip on time / R2 both low", {31'd0, cardPresent}, 32'd1);
    check("R4 pulse high", {31'd0, cardEvent}, 32'd1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'd0, cardEvent}, 32'd0);
    check("R4 insert event count", evtCnt - e0, 32'd1);
  endtask

  task automatic t_remove();
    int e0 = evtCnt;
    @(negedge clk);
    cdet2N = 1'b1;
    repeat (TB_DEB + 6) @(negedge clk);
    check("R2 one pin high means absent", {31'd0, cardPresent}, 32'd0);
    check("R4 removal event count", evtCnt - e0, 32'd1);
  endtask

  task automatic t_partial();
    int e0 = evtCnt;
    @(negedge clk);
    cdet1N = 1'b0; cdet2N = 1'b1;
    repeat (3 * TB_DEB) @(negedge clk);
    check("R2 only pin1 low", {31'd0, cardPresent}, 32'd0);
    cdet1N = 1'b1; cdet2N = 1'b0;
    repeat (3 * TB_DEB) @(negedge clk);
    check("R2 only pin2 low", {31'd0, cardPresent}, 32'd0);
    check("R2 no event", evtCnt - e0, 32'd0);
    cdet2N = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_glitch();
    int e0 = evtCnt;
    @(negedge clk);
    cdet1N = 1'b0; cdet2N = 1'b0;
    repeat (TB_DEB - 2) @(negedge clk);
    cdet1N = 1'b1; cdet2N = 1'b1;
    repeat (2 * TB_DEB) @(negedge clk);
    check("R3 short glitch ignored", {31'd0, cardPresent}, 32'd0);
    check("R3 glitch no event", evtCnt - e0, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d, m0, m1;
    @(negedge clk);
    cdet1N = 1'b1; cdet2N = 1'b0; cardRdy = 1'b1; ioRdy = 1'b0;
    repeat (3) @(negedge clk);
    rdReg(12'h000, d);
    check("R5 status pattern a", d, 32'h24);
    cdet1N = 1'b0; cdet2N = 1'b1; cardRdy = 1'b0; ioRdy = 1'b1;
    repeat (3) @(negedge clk);
    rdReg(12'h000, d);
    check("R5 status pattern b", d, 32'h48);
    rdReg(12'h00C, m0);
    wrReg(12'h000, 32'hFFFF_FFFF);
    rdReg(12'h00C, m1);
    check("R5 status write ignored", m1, m0);
    rdReg(12'h000, d);
    check("R5 status unchanged after write", d, 32'h48);
    cdet1N = 1'b1; cdet2N = 1'b1; ioRdy = 1'b0;
    repeat (TB_DEB + 6) @(negedge clk);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wrReg(12'h00C, 32'h8000_117E);
    rdReg(12'h00C, d);
    check("R6 mode masked", d, 32'h113E);
    check("R8 ifMode", {30'd0, ifMode}, 32'd2);
    check("R8 cardResetOut", {31'd0, cardResetOut}, 32'd1);
    check("R8 tristate", {31'd0, outTristate}, 32'd1);
    check("R8 fields", {26'd0, plusCard, udmaEn, mwdmaEn, 1'b0, blkSize}, {26'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2});
    check("R9 hold released", {31'd0, xferHold}, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wrReg(12'h00C, 32'hFFFF_FFFF);
    rdReg(12'h00C, d);
    check("R7 reserved mode kept, others written", d, 32'h1B3E);
    wrReg(12'h00C, 32'h0000_0011);
    rdReg(12'h00C, d);
    check("R6 mode 1 accepted, reset bit cleared", d, 32'h11);
    check("R8 cardResetOut low", {31'd0, cardResetOut}, 32'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wrReg(12'h00C, 32'h0000_1B3E);
    wrReg(12'h00C, 32'h0000_1B2E);
    rdReg(12'h00C, d);
    check("R9 config kept with host off", d, 32'h1B2E);
    check("R9 hold asserted", {31'd0, xferHold}, 32'd1);
    wrReg(12'h00C, 32'h0000_1B3E);
    check("R9 hold released again", {31'd0, xferHold}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rdReg(12'h004, d);
    check("R10 addr 0x004", d, 32'h0);
    rdReg(12'h010, d);
    check("R10 addr 0x010", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_insert();
    t_remove();
    t_partial();
    t_glitch();
    t_status();
    t_mode();
    t_reserved();
    t_soft_reset();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule